// File: doc/BRIEF.md
# Layered Overlay Raster Compositor

This block sits in a display pipeline after the pixel fetch stage. It receives the base framebuffer pixel stream together with the current raster coordinates. It also receives one pixel stream for each of two overlay planes, aligned to the same coordinate. For every valid input pixel it decides which plane is visible and emits that pixel one clock later. The output carries a tag that names the source plane and a tag that names the pixel format.

Each overlay is described by two 32-bit control words. These give the size, the bits-per-pixel code, the enable bit, the start position and, on the second overlay only, a pixel format. A global bit places both overlays above the base or below it. A configuration whose rectangle leaves the base plane is rejected, and so is one whose start column does not land on a 32-bit word boundary. A rejected overlay is treated as transparent. All configuration inputs are captured on the first pixel of a frame, so every pixel of a frame is composed with one configuration. Colour conversion is not done here: YUV pixels pass through unchanged, tagged with their format.

Top module: `ovl_compositor`

## Requirements
- R1: Every accepted pixel (`in_valid` high) appears on the outputs exactly one clock later, with `out_sof` and `out_eol` copied from the input markers. Without `in_valid`, `out_valid` is low on the next cycle and `out_pix` holds its value. After reset all output markers are low.
- R2: Bit 31 of control word 1 enables an overlay. A disabled overlay is transparent, so the plane beneath it shows.
- R3: Control word 1 holds width minus one in bits [9:0] and height minus one in bits [19:10]. Control word 2 holds the start column in bits [9:0] and the start row in bits [19:10]. An accepted overlay covers columns xpos..xpos+width-1 and rows ypos..ypos+height-1, with both ends included.
- R4: Where both overlays cover a pixel and are above the base, overlay 2 is shown.
- R5: With `ovl_on_top` high the overlays are drawn above the base. With it low the base pixel is always shown.
- R6: An overlay is rejected and not shown when xpos+width-1 exceeds `base_w_m1` or ypos+height-1 exceeds `base_h_m1`.
- R7: The bits-per-pixel code in control word 1 bits [23:20] maps to 0:1, 1:2, 2:4, 3:8, 4:16 and 5:24 bits. Any other code rejects an RGB overlay. The overlay is also rejected unless xpos times its effective bits is a multiple of 32.
- R8: Overlay 2 reads a format in control word 2 bits [22:20]. The values are 0 RGB (bits from the code), 1 YUV444 packed (24), 2 YUV444 planar (8), 3 YUV422 planar (4) and 4 YUV420 planar (2). Values 5 to 7 reject the overlay. `out_fmt` shows the format of a pixel taken from overlay 2 and shows 0 otherwise. Overlay 1 ignores bits [22:20].
- R9: Control words, base size and `ovl_on_top` are sampled on a valid start-of-frame pixel, and that pixel already uses the new values. Changes at any other time take effect only at the next start of frame.
- R10: `out_src` encodes the visible plane as 0 base, 1 overlay 1, 2 overlay 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_sof | input | 1 | First pixel of frame |
| in_eol | input | 1 | Last pixel of line |
| in_x | input | 10 | Current column |
| in_y | input | 10 | Current row |
| base_pix | input | PW | Base plane pixel |
| base_w_m1 | input | 10 | Base width minus one |
| base_h_m1 | input | 10 | Base height minus one |
| ovl_on_top | input | 1 | Overlays above base when high |
| o1_word1 | input | 32 | Overlay 1 size/depth/enable word |
| o1_word2 | input | 32 | Overlay 1 position word |
| o2_word1 | input | 32 | Overlay 2 size/depth/enable word |
| o2_word2 | input | 32 | Overlay 2 position/format word |
| o1_pix | input | PW | Overlay 1 pixel at (in_x, in_y) |
| o2_pix | input | PW | Overlay 2 pixel at (in_x, in_y) |
| out_valid | output | 1 | Output pixel valid |
| out_sof | output | 1 | Output first pixel of frame |
| out_eol | output | 1 | Output last pixel of line |
| out_pix | output | PW | Composed pixel |
| out_src | output | 2 | Visible plane code |
| out_fmt | output | 3 | Format of the visible pixel |

## Verification
The assertions assume two things about the inputs. First, the coordinate inputs describe the same raster that the base size describes. Second, every frame opens with a valid pixel carrying `in_sof`, so the latched configuration and the coordinates stay consistent. The stimulus meets both assumptions. It scans complete 16x8 frames in raster order, marks the pixel at (0,0) as start of frame, and ends every row with an end-of-line marker. Configuration inputs change only between pixels, and idle cycles are inserted at regular gaps to exercise the hold behaviour.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int unsigned CW = 10;

  typedef enum logic [1:0] {
    SRC_BASE = 2'd0,
    SRC_OVL1 = 2'd1,
    SRC_OVL2 = 2'd2
  } src_e;

  localparam logic [2:0] FMT_RGB     = 3'd0;
  localparam logic [2:0] FMT_LAST_OK = 3'd4;

  // Effective bits per pixel; zero marks an unusable setting.
  function automatic logic [5:0] eff_bits(input logic [2:0] fmt, input logic [3:0] code);
    logic [5:0] b;
    b = 6'd0;
    if (fmt == FMT_RGB) begin
      case (code)
        4'd0: b = 6'd1;
        4'd1: b = 6'd2;
        4'd2: b = 6'd4;
        4'd3: b = 6'd8;
        4'd4: b = 6'd16;
        4'd5: b = 6'd24;
        default: b = 6'd0;
      endcase
    end else begin
      case (fmt)
        3'd1: b = 6'd24;
        3'd2: b = 6'd8;
        3'd3: b = 6'd4;
        3'd4: b = 6'd2;
        default: b = 6'd0;
      endcase
    end
    return b;
  endfunction
endpackage

// File: rtl/ovl_layer.sv
module ovl_layer
  import ovl_pkg::*;
#(
  parameter bit HAS_FMT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [31:0]   word1_in,
  input  logic [31:0]   word2_in,
  input  logic [CW-1:0] base_w_m1,
  input  logic [CW-1:0] base_h_m1,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  output logic          hit,
  output logic [2:0]    fmt
);
  localparam int unsigned PW_PROD = CW + 6;

  logic [31:0] w1_q, w2_q, w1_d, w2_d, w1_eff, w2_eff;
  logic [2:0]  fmt_raw;
  logic [5:0]  bits;
  logic [PW_PROD-1:0] prod;
  logic [CW:0] right, bottom;
  logic        cfg_ok;
  logic        unused_bits;

  always_comb begin
    w1_d = w1_q;
    w2_d = w2_q;
    if (load) begin
      w1_d = word1_in;
      w2_d = word2_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w1_q <= '0;
      w2_q <= '0;
    end else begin
      w1_q <= w1_d;
      w2_q <= w2_d;
    end
  end

  // The start-of-frame pixel already sees the new words.
  assign w1_eff = load ? word1_in : w1_q;
  assign w2_eff = load ? word2_in : w2_q;

  generate
    if (HAS_FMT) begin : g_fmt
      assign fmt_raw = w2_eff[22:20];
    end else begin : g_rgb_only
      assign fmt_raw = FMT_RGB;
    end
  endgenerate

  assign unused_bits = ^{w1_eff[30:24], w2_eff[31:20]};

  assign bits   = eff_bits(fmt_raw, w1_eff[23:20]);
  assign prod   = {6'd0, w2_eff[CW-1:0]} * {{CW{1'b0}}, bits};
  assign right  = {1'b0, w2_eff[CW-1:0]} + {1'b0, w1_eff[CW-1:0]};
  assign bottom = {1'b0, w2_eff[2*CW-1:CW]} + {1'b0, w1_eff[2*CW-1:CW]};

  always_comb begin
    cfg_ok = w1_eff[31];
    if (bits == 6'd0)                   cfg_ok = 1'b0;
    if (fmt_raw > FMT_LAST_OK)          cfg_ok = 1'b0;
    if (prod[4:0] != 5'd0)              cfg_ok = 1'b0;
    if (right  > {1'b0, base_w_m1})     cfg_ok = 1'b0;
    if (bottom > {1'b0, base_h_m1})     cfg_ok = 1'b0;
  end

  assign hit = cfg_ok
             && (x >= w2_eff[CW-1:0])    && ({1'b0, x} <= right)
             && (y >= w2_eff[2*CW-1:CW]) && ({1'b0, y} <= bottom);
  assign fmt = fmt_raw;

  // R6: a shown overlay pixel always lies inside the base plane
  a_r6_hit_inside_base: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (x <= base_w_m1) && (y <= base_h_m1));

  // R8: a shown overlay never carries a reserved format
  a_r8_hit_fmt_legal: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (fmt <= FMT_LAST_OK));
endmodule

// File: rtl/ovl_pick.sv
module ovl_pick
  import ovl_pkg::*;
#(
  parameter int unsigned PW = 24
) (
  input  logic          on_top,
  input  logic [1:0]    hit,
  input  logic [2:0]    fmt2,
  input  logic [PW-1:0] base_pix,
  input  logic [PW-1:0] o1_pix,
  input  logic [PW-1:0] o2_pix,
  output logic [PW-1:0] pix,
  output src_e          src,
  output logic [2:0]    fmt
);
  always_comb begin
    pix = base_pix;
    src = SRC_BASE;
    fmt = FMT_RGB;
    if (on_top) begin
      if (hit[1]) begin
        pix = o2_pix;
        src = SRC_OVL2;
        fmt = fmt2;
      end else if (hit[0]) begin
        pix = o1_pix;
        src = SRC_OVL1;
      end
    end
  end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_pkg::*;
#(
  parameter int unsigned PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eol,
  input  logic [9:0]    in_x,
  input  logic [9:0]    in_y,
  input  logic [PW-1:0] base_pix,
  input  logic [9:0]    base_w_m1,
  input  logic [9:0]    base_h_m1,
  input  logic          ovl_on_top,
  input  logic [31:0]   o1_word1,
  input  logic [31:0]   o1_word2,
  input  logic [31:0]   o2_word1,
  input  logic [31:0]   o2_word2,
  input  logic [PW-1:0] o1_pix,
  input  logic [PW-1:0] o2_pix,
  output logic          out_valid,
  output logic          out_sof,
  output logic          out_eol,
  output logic [PW-1:0] out_pix,
  output logic [1:0]    out_src,
  output logic [2:0]    out_fmt
);
  localparam int unsigned NLAYER = 2;

  logic          load;
  logic [CW-1:0] bw_q, bh_q, bw_d, bh_d, bw_eff, bh_eff;
  logic          top_q, top_d, top_eff;
  logic [31:0]   w1_arr [NLAYER];
  logic [31:0]   w2_arr [NLAYER];
  logic [NLAYER-1:0] hit;
  logic [2:0]    fmt_arr [NLAYER];
  logic [PW-1:0] pix_d;
  src_e          src_d;
  logic [2:0]    fmt_d;
  logic          unused_fmt1;

  assign load = in_valid & in_sof;

  // Frame-boundary capture of the global settings.
  always_comb begin
    bw_d  = bw_q;
    bh_d  = bh_q;
    top_d = top_q;
    if (load) begin
      bw_d  = base_w_m1;
      bh_d  = base_h_m1;
      top_d = ovl_on_top;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bw_q  <= '0;
      bh_q  <= '0;
      top_q <= 1'b0;
    end else begin
      bw_q  <= bw_d;
      bh_q  <= bh_d;
      top_q <= top_d;
    end
  end

  assign bw_eff  = load ? base_w_m1  : bw_q;
  assign bh_eff  = load ? base_h_m1  : bh_q;
  assign top_eff = load ? ovl_on_top : top_q;

  assign w1_arr[0] = o1_word1;
  assign w2_arr[0] = o1_word2;
  assign w1_arr[1] = o2_word1;
  assign w2_arr[1] = o2_word2;

  genvar gi;
  generate
    for (gi = 0; gi < NLAYER; gi++) begin : g_layer
      ovl_layer #(.HAS_FMT(gi == 1)) u_layer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .word1_in  (w1_arr[gi]),
        .word2_in  (w2_arr[gi]),
        .base_w_m1 (bw_eff),
        .base_h_m1 (bh_eff),
        .x         (in_x),
        .y         (in_y),
        .hit       (hit[gi]),
        .fmt       (fmt_arr[gi])
      );
    end
  endgenerate

  assign unused_fmt1 = ^fmt_arr[0];

  ovl_pick #(.PW(PW)) u_pick (
    .on_top   (top_eff),
    .hit      (hit),
    .fmt2     (fmt_arr[1]),
    .base_pix (base_pix),
    .o1_pix   (o1_pix),
    .o2_pix   (o2_pix),
    .pix      (pix_d),
    .src      (src_d),
    .fmt      (fmt_d)
  );

  // Output stage: markers every cycle, data only with a valid pixel.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
      out_pix   <= '0;
      out_src   <= SRC_BASE;
      out_fmt   <= FMT_RGB;
    end else begin
      out_valid <= in_valid;
      out_sof   <= in_valid & in_sof;
      out_eol   <= in_valid & in_eol;
      if (in_valid) begin
        out_pix <= pix_d;
        out_src <= src_d;
        out_fmt <= fmt_d;
      end
    end
  end

  // R1: one-cycle latency for valid
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1: no valid input, no output and data held
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_pix));
  // R1: markers only ride on valid pixels
  a_r1_marker_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eol) |-> out_valid);
  // R5: an overlay can only win while overlays are above the base
  a_r5_under_shows_base: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !top_eff |=> out_src == SRC_BASE);
  // R8: format tag is non-RGB only for overlay 2 pixels
  a_r8_fmt_only_ovl2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_src != SRC_OVL2) |-> out_fmt == FMT_RGB);
  // R10: source code stays within its three legal values
  a_r10_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_src != 2'd3);
endmodule

// File: tb/test_ovl_compositor.sv
module test_ovl_compositor;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PW = 24;
  localparam int BW = 16;
  localparam int BH = 8;

  logic          clk, rst_n;
  logic          in_valid, in_sof, in_eol;
  logic [9:0]    in_x, in_y;
  logic [PW-1:0] base_pix, o1_pix, o2_pix;
  logic [9:0]    base_w_m1, base_h_m1;
  logic          ovl_on_top;
  logic [31:0]   o1_word1, o1_word2, o2_word1, o2_word2;
  logic          out_valid, out_sof, out_eol;
  logic [PW-1:0] out_pix;
  logic [1:0]    out_src;
  logic [2:0]    out_fmt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [PW-1:0] pix;
    logic [1:0]    src;
    logic [2:0]    fmt;
    logic          sof;
    logic          eol;
    string         tag;
  } exp_t;
  exp_t q[$];

  // bench copy of the frame configuration
  logic [31:0] sh_w1 [2];
  logic [31:0] sh_w2 [2];
  logic        sh_top;
  // configuration applied mid-frame
  logic [31:0] nx_w1 [2];
  logic [31:0] nx_w2 [2];
  logic        nx_top;

  ovl_compositor #(.PW(PW)) i_ovl_compositor (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_x(in_x), .in_y(in_y), .base_pix(base_pix), .base_w_m1(base_w_m1),
    .base_h_m1(base_h_m1), .ovl_on_top(ovl_on_top), .o1_word1(o1_word1),
    .o1_word2(o1_word2), .o2_word1(o2_word1), .o2_word2(o2_word2), .o1_pix(o1_pix),
    .o2_pix(o2_pix), .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_pix(out_pix), .out_src(out_src), .out_fmt(out_fmt));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int m_bits(input int f, input int code);
    if (f == 0) begin
      case (code)
        0: return 1;  1: return 2;  2: return 4;
        3: return 8;  4: return 16; 5: return 24;
        default: return 0;
      endcase
    end
    case (f)
      1: return 24; 2: return 8; 3: return 4; 4: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_show(input int idx, input int x, input int y);
    int f, b, xp, yp, wm, hm;
    f  = (idx == 1) ? int'(sh_w2[idx][22:20]) : 0;
    b  = m_bits(f, int'(sh_w1[idx][23:20]));
    xp = int'(sh_w2[idx][9:0]);
    yp = int'(sh_w2[idx][19:10]);
    wm = int'(sh_w1[idx][9:0]);
    hm = int'(sh_w1[idx][19:10]);
    if (!sh_w1[idx][31] || b == 0) return 1'b0;
    if (((xp * b) % 32) != 0) return 1'b0;
    if (xp + wm > BW - 1 || yp + hm > BH - 1) return 1'b0;
    return (x >= xp) && (x <= xp + wm) && (y >= yp) && (y <= yp + hm);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic put_pixel(input string tag, input int x, input int y, input bit sof, input bit eol);
    exp_t e;
    @(posedge clk); #1;
    in_valid = 1'b1; in_sof = sof; in_eol = eol;
    in_x = 10'(x); in_y = 10'(y);
    base_pix = {8'hBA, 8'(y), 8'(x)};
    o1_pix   = {8'h11, 8'(y), 8'(x)};
    o2_pix   = {8'h22, 8'(y), 8'(x)};
    if (sof) begin
      sh_w1[0] = o1_word1; sh_w2[0] = o1_word2;
      sh_w1[1] = o2_word1; sh_w2[1] = o2_word2;
      sh_top = ovl_on_top;
    end
    e.pix = base_pix; e.src = 2'd0; e.fmt = 3'd0;   // R10 codes: 0 base
    if (sh_top) begin
      if (m_show(1, x, y)) begin
        e.pix = o2_pix; e.src = 2'd2; e.fmt = sh_w2[1][22:20];
      end else if (m_show(0, x, y)) begin
        e.pix = o1_pix; e.src = 2'd1;
      end
    end
    e.sof = sof; e.eol = eol; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
  endtask

  task automatic frame(input string tag, input int chg_at);
    int n;
    n = 0;
    for (int y = 0; y < BH; y++) begin
      for (int x = 0; x < BW; x++) begin
        if (n == chg_at) begin
          o1_word1 = nx_w1[0]; o1_word2 = nx_w2[0];
          o2_word1 = nx_w1[1]; o2_word2 = nx_w2[1];
          ovl_on_top = nx_top;
        end
        put_pixel(tag, x, y, (x == 0 && y == 0), (x == BW - 1));
        n++;
        if (n % 7 == 0) idle();
      end
    end
    idle();
  endtask

  function automatic logic [31:0] w1(input bit en, input int bpp, input int hm, input int wm);
    return {en, 7'd0, 4'(bpp), 10'(hm), 10'(wm)};
  endfunction
  function automatic logic [31:0] w2(input int fmt, input int yp, input int xp);
    return {9'd0, 3'(fmt), 10'(yp), 10'(xp)};
  endfunction

  // monitor: compare in order, and check hold on idle cycles (R1)
  initial begin
    exp_t e;
    logic [PW-1:0] last;
    bit seen;
    seen = 0;
    last = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (out_valid) begin
          if (q.size() == 0) begin
            check(1'b0, "R1", "unexpected out_valid", 32'd1, 32'd0);
          end else begin
            e = q.pop_front();
            check(out_pix == e.pix, e.tag, "pix", 32'(out_pix), 32'(e.pix));
            check(out_src == e.src, e.tag, "src(R10)", 32'(out_src), 32'(e.src));
            check(out_fmt == e.fmt, e.tag, "fmt", 32'(out_fmt), 32'(e.fmt));
            check({out_sof, out_eol} == {e.sof, e.eol}, "R1", "markers",
                  32'({out_sof, out_eol}), 32'({e.sof, e.eol}));
          end
          last = out_pix;
          seen = 1;
        end else if (seen) begin
          check(out_pix == last, "R1", "hold on idle", 32'(out_pix), 32'(last));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_sof = 0; in_eol = 0; in_x = '0; in_y = '0;
    base_pix = '0; o1_pix = '0; o2_pix = '0;
    base_w_m1 = 10'(BW - 1); base_h_m1 = 10'(BH - 1);
    ovl_on_top = 1'b1;
    o1_word1 = '0; o1_word2 = '0; o2_word1 = '0; o2_word2 = '0;
    repeat (3) @(negedge clk);
    check({out_valid, out_sof, out_eol} == 3'b000, "R1", "reset markers",
          32'({out_valid, out_sof, out_eol}), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2: both disabled (enable bit low) -> base everywhere
    o1_word1 = w1(0, 4, 2, 3); o1_word2 = w2(0, 1, 2);
    frame("R2", -1);

    // R4: overlay1 16bpp at (2,1) 4x3, overlay2 YUV420 at (0,2) 8x2, overlapping
    o1_word1 = w1(1, 4, 2, 3); o1_word2 = w2(0, 1, 2);
    o2_word1 = w1(1, 0, 1, 7); o2_word2 = w2(4, 2, 0);
    frame("R4", -1);

    // R5: same layers, placed under the base
    ovl_on_top = 1'b0;
    frame("R5", -1);
    ovl_on_top = 1'b1;

    // R7: overlay1 at odd column with 16 bits -> misaligned, rejected
    o1_word2 = w2(0, 1, 3);
    o2_word1 = '0;
    frame("R7", -1);

    // R6: overlay2 RGB 24 bits at column 12, width 8 -> past right edge
    o1_word1 = '0;
    o2_word1 = w1(1, 5, 0, 7); o2_word2 = w2(0, 6, 12);
    frame("R6", -1);

    // R3: overlay2 RGB 24 bits at column 4 width 12 touching last column and row
    o2_word1 = w1(1, 5, 1, 11); o2_word2 = w2(0, 6, 4);
    frame("R3", -1);

    // R8: overlay2 reserved format rejected; overlay1 ignores format bits
    o1_word1 = w1(1, 3, 1, 3); o1_word2 = w2(3, 3, 4);
    o2_word1 = w1(1, 0, 1, 7); o2_word2 = w2(5, 0, 0);
    frame("R8", -1);
    // R8: overlay2 YUV422 planar shows with format tag 3
    o2_word1 = w1(1, 0, 2, 7); o2_word2 = w2(3, 4, 8);
    frame("R8", -1);

    // R9: change everything mid-frame; effective only from the next frame
    o1_word1 = w1(1, 4, 2, 3); o1_word2 = w2(0, 1, 2);
    o2_word1 = w1(1, 0, 1, 7); o2_word2 = w2(4, 2, 0);
    nx_w1[0] = '0; nx_w2[0] = '0; nx_w1[1] = w1(1, 2, 7, 15); nx_w2[1] = w2(0, 0, 0);
    nx_top = 1'b1;
    frame("R9", 40);
    frame("R9", -1);

    repeat (4) @(posedge clk);
    check(q.size() == 0, "R1", "all outputs seen", 32'(q.size()), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule